// File: doc/BRIEF.md
# IPv4 Header Validation Stage

This stage sits in a router's receive pipeline and inspects every Ethernet frame that streams through it as 64-bit words. It picks the IPv4 header out of the frame, checks that the header is sound, and applies a fixed set of acceptance rules. For every frame it issues exactly one verdict: forward on the fast path, hand to the host processor, or drop.

A forwarded frame comes with its destination address, the TTL already reduced by one, and a header checksum that has been adjusted for the new TTL. Downstream logic does the route lookup and rewrites the header. A frame that arrives with an expiring TTL is flagged so that a later stage can build a time-exceeded message.

The verdict is presented on the same cycle as the frame's last word is accepted. Backpressure from the verdict consumer is passed straight back to the word source, so a verdict can never be lost and frames may follow each other with no idle cycles between them.

Top module: `ipv4_hdr_check`

## Requirements
- R1: The verdict strobe `vd_valid` is high for exactly one cycle per frame: the cycle in which the frame's end-marked word is accepted. `vd_code` is then 2'b00 (forward), 2'b01 (to CPU) or 2'b10 (drop), and never 2'b11.
- R2: `in_ready` equals `vd_ready`. While `vd_ready` is low no word is accepted and `vd_valid` stays low.
- R3: Byte 0 of a word sits in bits 63:56. A frame begins with a 14-byte Ethernet header, and the IPv4 header starts at byte 14. If the ethertype in bytes 12–13 is not 16'h0800, or the version nibble (high half of byte 14) is not 4, the frame goes to the CPU.
- R4: If the header-length nibble (low half of byte 14) is below 5, the frame is dropped. If it is above 5 (options present), the frame goes to the CPU.
- R5: The ten 16-bit header words (bytes 14–33) are summed in ones'-complement arithmetic with end-around carry. If the sum is not 16'hFFFF, the frame is dropped.
- R6: If the TTL (byte 22) is 0 or 1, the frame goes to the CPU and `vd_ttl_exp` is high. In every other case `vd_ttl_exp` is low.
- R7: If the IPv4 total length (bytes 16–17) is outside 64..1500 inclusive, the frame goes to the CPU.
- R8: For a forwarded frame, `vd_dst` is bytes 30–33, `vd_ttl` is the TTL minus one, and `vd_csum` is the old checksum plus 16'h0100 in ones'-complement arithmetic. The rewritten header therefore still sums to 16'hFFFF.
- R9: A frame whose end marker falls within its first five words (header not complete) is dropped.
- R10: When several rules apply, the first one in this order decides: truncation (drop), non-IPv4 (CPU), short header length (drop), options (CPU), bad checksum (drop), expiring TTL (CPU), length out of range (CPU).
- R11: Frames sent back to back, with a start marker on the cycle after the previous end marker, each receive their own correct verdict.
- R12: After reset, `vd_valid` is low until an end-marked word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 64 | Frame word, first byte in the top bits |
| in_sop | input | 1 | Marks the first word of a frame |
| in_eop | input | 1 | Marks the last word of a frame |
| in_valid | input | 1 | Word on in_data is valid |
| in_ready | output | 1 | Stage accepts the word this cycle |
| vd_ready | input | 1 | Verdict consumer can take a verdict |
| vd_valid | output | 1 | Verdict strobe |
| vd_code | output | 2 | 00 forward, 01 CPU, 10 drop |
| vd_ttl_exp | output | 1 | TTL expired, time-exceeded message needed |
| vd_dst | output | 32 | Destination address |
| vd_ttl | output | 8 | TTL minus one |
| vd_csum | output | 16 | Checksum adjusted for the new TTL |

## Verification
The assertions assume that every frame starts with a start-marked word and that `in_valid` stays high on a word until it is accepted. They also assume that the start marker on a frame's first word is what restarts word counting. The bench drives only whole, well-framed word sequences. It holds each word until `in_ready` is seen, and it changes inputs only just after a clock edge, so the rules on the inputs always hold. Within those limits, the bench sweeps every TTL value, every version and header-length nibble, the total-length boundaries, single-bit checksum faults, truncated frames and verdict backpressure.

// File: rtl/ipv4v_pkg.sv
package ipv4v_pkg;
  localparam int WORD_W   = 64;
  localparam int IDX_W    = 3;
  localparam int HDR_WDS  = 5;   // words 0..4 hold Ethernet + IPv4 header
  localparam int ACC_W    = 20;  // ten 16-bit terms fit without overflow

  typedef enum logic [1:0] {
    VD_FWD  = 2'b00,
    VD_CPU  = 2'b01,
    VD_DROP = 2'b10
  } vd_code_e;
endpackage

// File: rtl/ipv4v_rst_sync.sv
module ipv4v_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/ipv4v_field_cap.sv
module ipv4v_field_cap
  import ipv4v_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              sop,
  input  logic              eop,
  input  logic [WORD_W-1:0] data,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              hdr_full,
  output logic [15:0]       etype,
  output logic [3:0]        ver,
  output logic [3:0]        ihl,
  output logic [15:0]       tlen,
  output logic [7:0]        ttl,
  output logic [15:0]       csum,
  output logic [31:0]       dst
);
  logic [IDX_W-1:0] idx_q, idx_n;

  assign cur_idx  = sop ? '0 : idx_q;
  assign hdr_full = (cur_idx == IDX_W'(HDR_WDS));

  always_comb begin
    idx_n = idx_q;
    if (beat) begin
      if (eop)            idx_n = '0;
      else if (!hdr_full) idx_n = cur_idx + 1'b1;
      else                idx_n = cur_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_n;
  end

  // header fields: datapath registers, written only on their word
  always_ff @(posedge clk) begin
    if (beat && cur_idx == IDX_W'(1)) begin
      etype <= data[31:16];
      ver   <= data[15:12];
      ihl   <= data[11:8];
    end
    if (beat && cur_idx == IDX_W'(2)) begin
      tlen  <= data[63:48];
      ttl   <= data[15:8];
    end
    if (beat && cur_idx == IDX_W'(3)) begin
      csum       <= data[63:48];
      dst[31:16] <= data[15:0];
    end
    if (beat && cur_idx == IDX_W'(4)) begin
      dst[15:0]  <= data[63:48];
    end
  end
endmodule

// File: rtl/ipv4v_csum.sv
module ipv4v_csum
  import ipv4v_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [WORD_W-1:0] data,
  output logic              sum_ok
);
  logic [ACC_W-1:0] acc_q, acc_n;
  logic [16:0]      fold1;
  logic [15:0]      fold2;

  always_comb begin
    acc_n = acc_q;
    if (beat) begin
      case (cur_idx)
        IDX_W'(1): acc_n = ACC_W'(data[15:0]);
        IDX_W'(2),
        IDX_W'(3): acc_n = acc_q + ACC_W'(data[63:48]) + ACC_W'(data[47:32])
                                 + ACC_W'(data[31:16]) + ACC_W'(data[15:0]);
        IDX_W'(4): acc_n = acc_q + ACC_W'(data[63:48]);
        default:   acc_n = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end

  assign fold1  = 17'(acc_q[15:0]) + 17'(acc_q[ACC_W-1:16]);
  assign fold2  = fold1[15:0] + 16'(fold1[16]);
  assign sum_ok = (fold2 == 16'hFFFF);
endmodule

// File: rtl/ipv4v_decide.sv
module ipv4v_decide
  import ipv4v_pkg::*;
#(
  parameter logic [15:0] ETYPE_IP = 16'h0800,
  parameter int          LEN_MIN  = 64,
  parameter int          LEN_MAX  = 1500
) (
  input  logic        hdr_full,
  input  logic [15:0] etype,
  input  logic [3:0]  ver,
  input  logic [3:0]  ihl,
  input  logic [15:0] tlen,
  input  logic [7:0]  ttl,
  input  logic [15:0] csum,
  input  logic        sum_ok,
  output vd_code_e    code,
  output logic        ttl_exp,
  output logic [7:0]  new_ttl,
  output logic [15:0] new_csum
);
  logic [16:0] inc;
  logic        len_ok;

  assign len_ok   = (tlen >= 16'(LEN_MIN)) && (tlen <= 16'(LEN_MAX));
  assign inc      = 17'(csum) + 17'h0_0100;
  assign new_csum = inc[15:0] + 16'(inc[16]);
  assign new_ttl  = ttl - 8'd1;

  always_comb begin
    ttl_exp = 1'b0;
    if (!hdr_full)                              code = VD_DROP;
    else if (etype != ETYPE_IP || ver != 4'd4)  code = VD_CPU;
    else if (ihl < 4'd5)                        code = VD_DROP;
    else if (ihl > 4'd5)                        code = VD_CPU;
    else if (!sum_ok)                           code = VD_DROP;
    else if (ttl <= 8'd1) begin
      code    = VD_CPU;
      ttl_exp = 1'b1;
    end
    else if (!len_ok)                           code = VD_CPU;
    else                                        code = VD_FWD;
  end
endmodule

// File: rtl/ipv4_hdr_check.sv
module ipv4_hdr_check
  import ipv4v_pkg::*;
#(
  parameter logic [15:0] ETYPE_IP = 16'h0800,
  parameter int          LEN_MIN  = 64,
  parameter int          LEN_MAX  = 1500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              vd_ready,
  output logic              vd_valid,
  output logic [1:0]        vd_code,
  output logic              vd_ttl_exp,
  output logic [31:0]       vd_dst,
  output logic [7:0]        vd_ttl,
  output logic [15:0]       vd_csum
);
  logic             srst_n, beat, hdr_full, sum_ok;
  logic [IDX_W-1:0] cur_idx;
  logic [15:0]      etype, tlen, csum;
  logic [3:0]       ver, ihl;
  logic [7:0]       ttl;
  vd_code_e         code;

  assign in_ready = vd_ready;
  assign beat     = in_valid & in_ready;
  assign vd_valid = beat & in_eop;
  assign vd_code  = code;

  ipv4v_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(srst_n));

  ipv4v_field_cap u_cap (
    .clk(clk), .rst_n(srst_n), .beat(beat), .sop(in_sop), .eop(in_eop),
    .data(in_data), .cur_idx(cur_idx), .hdr_full(hdr_full), .etype(etype),
    .ver(ver), .ihl(ihl), .tlen(tlen), .ttl(ttl), .csum(csum), .dst(vd_dst)
  );

  ipv4v_csum u_sum (
    .clk(clk), .rst_n(srst_n), .beat(beat), .cur_idx(cur_idx),
    .data(in_data), .sum_ok(sum_ok)
  );

  ipv4v_decide #(.ETYPE_IP(ETYPE_IP), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)) u_dec (
    .hdr_full(hdr_full), .etype(etype), .ver(ver), .ihl(ihl), .tlen(tlen),
    .ttl(ttl), .csum(csum), .sum_ok(sum_ok), .code(code),
    .ttl_exp(vd_ttl_exp), .new_ttl(vd_ttl), .new_csum(vd_csum)
  );
endmodule

// File: rtl/ipv4v_checker.sv
module ipv4v_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_sop,
  input logic       in_eop,
  input logic       in_valid,
  input logic       in_ready,
  input logic       vd_ready,
  input logic       vd_valid,
  input logic [1:0] vd_code,
  input logic       vd_ttl_exp,
  input logic [7:0] vd_ttl
);
  logic [2:0] wc_q;
  logic [2:0] wc_cur;

  assign wc_cur = in_sop ? 3'd0 : wc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wc_q <= 3'd0;
    else if (in_valid && in_ready) begin
      if (in_eop)              wc_q <= 3'd0;
      else if (wc_cur != 3'd7) wc_q <= wc_cur + 3'd1;
    end
  end

  assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vd_valid |-> vd_code != 2'b11);

  assert_no_verdict_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !vd_valid);

  assert_hold_when_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vd_ready |-> !vd_valid);

  assert_expiry_to_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && vd_ttl_exp) |-> vd_code == 2'b01);

  assert_fwd_ttl_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && vd_code == 2'b00) |-> (!vd_ttl_exp && vd_ttl != 8'd0));

  assert_short_frame_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && wc_cur < 3'd5) |-> vd_code == 2'b10);
endmodule

bind ipv4_hdr_check ipv4v_checker u_chk (.*);

// File: tb/sim_ipv4_hdr_check.sv
module sim_ipv4_hdr_check;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] in_data;
  logic        in_sop, in_eop, in_valid, in_ready, vd_ready;
  logic        vd_valid, vd_ttl_exp;
  logic [1:0]  vd_code;
  logic [31:0] vd_dst;
  logic [7:0]  vd_ttl;
  logic [15:0] vd_csum;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] fb [0:79];
  bit bp_on = 1'b0;

  always #5 clk = ~clk;

  ipv4_hdr_check u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] fold(input logic [19:0] a);
    logic [16:0] t;
    t = 17'(a[15:0]) + 17'(a[19:16]);
    return t[15:0] + 16'(t[16]);
  endfunction

  function automatic logic [15:0] hdr_sum();
    logic [19:0] a = '0;
    for (int k = 14; k < 34; k += 2) a += 20'({fb[k], fb[k+1]});
    return fold(a);
  endfunction

  // build one 80-byte frame; cflip corrupts the checksum
  task automatic mk(input logic [15:0] et, input logic [3:0] ver, input logic [3:0] ihl,
                    input logic [15:0] tlen, input logic [7:0] ttl, input logic [15:0] cflip);
    for (int k = 0; k < 80; k++) fb[k] = 8'(k * 7 + 3);
    {fb[12], fb[13]} = et;
    fb[14] = {ver, ihl};
    fb[15] = 8'h00;
    {fb[16], fb[17]} = tlen;
    fb[22] = ttl;
    fb[23] = 8'd17;
    {fb[30], fb[31], fb[32], fb[33]} = 32'hC0A8_0A05 + 32'(ttl);
    {fb[24], fb[25]} = 16'h0000;
    {fb[24], fb[25]} = ~hdr_sum() ^ cflip;
  endtask

  function automatic logic [1:0] expect_code(input logic [15:0] et, input logic [3:0] ver,
      input logic [3:0] ihl, input logic [15:0] tlen, input logic [7:0] ttl,
      input bit bad, input int nw);
    if (nw <= 5)                         return 2'b10;
    if (et != 16'h0800 || ver != 4'd4)   return 2'b01;
    if (ihl < 5)                         return 2'b10;
    if (ihl > 5)                         return 2'b01;
    if (bad)                             return 2'b10;
    if (ttl <= 1)                        return 2'b01;
    if (tlen < 64 || tlen > 1500)        return 2'b01;
    return 2'b00;
  endfunction

  // send the frame in fb as nw words, check the verdict at the last word
  task automatic send(input int nw, input logic [1:0] ecode, input bit eexp, input string req);
    int flip = 0;
    for (int i = 0; i < nw; i++) begin
      bit done = 1'b0;
      while (!done) begin
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_sop   = (i == 0);
        in_eop   = (i == nw - 1);
        for (int b = 0; b < 8; b++) in_data[63 - 8*b -: 8] = fb[8*i + b];
        if (bp_on) begin vd_ready = flip[0]; flip++; end
        @(negedge clk);
        if (!in_ready) begin
          check(vd_valid == 1'b0, "R2 no verdict while blocked", 32'(vd_valid), 0);
          check(in_ready == vd_ready, "R2 ready follows consumer", 32'(in_ready), 32'(vd_ready));
        end else begin
          done = 1'b1;
          if (i != nw - 1)
            check(vd_valid == 1'b0, "R1 no verdict mid-frame", 32'(vd_valid), 0);
        end
      end
    end
    check(vd_valid == 1'b1, "R1 verdict at last word", 32'(vd_valid), 1);
    check(vd_code == ecode, req, 32'(vd_code), 32'(ecode));
    check(vd_ttl_exp == eexp, "R6 expiry flag", 32'(vd_ttl_exp), 32'(eexp));
    if (ecode == 2'b00) begin
      check(vd_dst == {fb[30], fb[31], fb[32], fb[33]}, "R8 destination", vd_dst,
            {fb[30], fb[31], fb[32], fb[33]});
      check(vd_ttl == fb[22] - 8'd1, "R8 ttl minus one", 32'(vd_ttl), 32'(fb[22] - 8'd1));
      fb[22] = vd_ttl;
      {fb[24], fb[25]} = vd_csum;
      check(hdr_sum() == 16'hFFFF, "R8 updated checksum", 32'(vd_csum), 32'hFFFF);
    end
  endtask

  task automatic run(input logic [15:0] et, input logic [3:0] ver, input logic [3:0] ihl,
                     input logic [15:0] tlen, input logic [7:0] ttl, input logic [15:0] cflip,
                     input int nw, input string req);
    logic [1:0] ec;
    mk(et, ver, ihl, tlen, ttl, cflip);
    ec = expect_code(et, ver, ihl, tlen, ttl, cflip != 0, nw);
    send(nw, ec, (ec == 2'b01) && nw > 5 && et == 16'h0800 && ver == 4 && ihl == 5
                 && cflip == 0 && ttl <= 1, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired got=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lens [0:8];
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_data = '0; vd_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(vd_valid == 1'b0, "R12 reset idle", 32'(vd_valid), 0);
    check(in_ready == 1'b1, "R2 ready after reset", 32'(in_ready), 1);

    // TTL sweep, frames back to back (R6, R8, R11)
    for (int t = 0; t < 256; t++) run(16'h0800, 4, 5, 16'd500, 8'(t), 0, 10, "R6 R11 ttl sweep");
    // version and header length nibbles (R3, R4)
    for (int v = 0; v < 16; v++) run(16'h0800, 4'(v), 5, 16'd300, 8'd64, 0, 10, "R3 version");
    for (int h = 0; h < 16; h++) run(16'h0800, 4, 4'(h), 16'd300, 8'd64, 0, 10, "R4 header length");
    run(16'h86DD, 4, 5, 16'd300, 8'd64, 0, 10, "R3 ethertype");
    run(16'h0806, 4, 5, 16'd300, 8'd64, 0, 9, "R3 ethertype");
    // single-bit checksum faults (R5)
    for (int b = 0; b < 16; b++) run(16'h0800, 4, 5, 16'd900, 8'd30, 16'(1 << b), 10, "R5 checksum");
    // total length boundaries (R7)
    lens = '{16'd0, 16'd20, 16'd63, 16'd64, 16'd65, 16'd1499, 16'd1500, 16'd1501, 16'hFFFF};
    for (int l = 0; l < 9; l++) run(16'h0800, 4, 5, lens[l], 8'd64, 0, 10, "R7 length");
    // truncated frames (R9)
    for (int n = 1; n <= 7; n++) run(16'h0800, 4, 5, 16'd300, 8'd64, 0, n, "R9 truncation");
    // rule priority (R10)
    run(16'h0800, 4, 5, 16'd300, 8'd1, 16'h0040, 10, "R10 checksum before ttl");
    run(16'h0800, 4, 6, 16'd300, 8'd64, 16'h0001, 10, "R10 options before checksum");
    run(16'h0801, 4, 3, 16'd300, 8'd64, 16'h0001, 10, "R10 non-ip first");
    run(16'h0800, 4, 5, 16'd10, 8'd0, 0, 10, "R10 ttl before length");
    run(16'h0800, 5, 2, 16'd300, 8'd64, 0, 4, "R10 truncation first");
    // backpressure from verdict consumer (R2)
    bp_on = 1'b1;
    for (int t = 2; t < 6; t++) run(16'h0800, 4, 5, 16'd600, 8'(t), 0, 8, "R2 backpressure");
    run(16'h0800, 4, 7, 16'd600, 8'd9, 0, 8, "R2 backpressure");
    bp_on = 1'b0;
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; vd_ready = 1'b1;
    @(negedge clk);
    check(vd_valid == 1'b0, "R1 idle after traffic", 32'(vd_valid), 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule